// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Port

This block moves one byte at a time over two wires: a serial clock and a single data line that carries traffic in only one direction at a time. As clock master it makes the serial clock from the system clock. Four divide ratios are available: 16, 8, 4 and 2. As clock slave it follows a clock from an external master. That clock passes through a two-flop synchronizer, and its edges are found in the system clock domain. The data line is sampled on every rising serial clock edge, whatever the idle level. New data is put out on falling edges. Bytes go out most significant bit first. A direction control decides whether the port drives the data line. The line is driven only when the port is enabled, is master, and has transmit selected. In every other case its output enable is low, so the pad is high-impedance.

Software-facing controls arrive as plain inputs: enable, master select, clock idle level, direction and a two-bit rate code. A write strobe loads the transmit byte. In master mode, a write strobe while idle also starts a transfer. A read strobe acknowledges the received byte. A completion flag rises after the eighth sampling edge. A read or a write clears it.

The controller has four states. OFF: disabled. READY: enabled master, waiting. SHIFT: master transfer running. LISTEN: enabled slave.
- OFF goes to READY when the port is enabled as master, or to LISTEN when it is enabled as slave.
- READY goes to SHIFT on a transmit write, to LISTEN when master is cleared, and to OFF when enable is cleared.
- SHIFT goes back to READY after the sixteenth clock half-period. Clearing enable aborts to OFF. Clearing master aborts to LISTEN.
- LISTEN goes to READY when master is set, and to OFF when enable is cleared.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset, sck_oe, sdio_oe and done_flag are 0 and rx_data is 0x00.
- R2: As master, each half-period of sck_o lasts 8, 4, 2 or 1 system clocks for cfg_rate 00, 01, 10 or 11, which divides the system clock by 16, 8, 4 or 2.
- R3: While no master transfer runs, sck_o equals cfg_cpol. A master transfer makes exactly 16 sck_o transitions and ends at the cfg_cpol level.
- R4: The transmit byte leaves on sdio_o most significant bit first. Bit 7 is present before the first rising edge. After a transfer's first rising edge, sdio_o changes only in the cycle in which sck_o falls.
- R5: rx_data holds the 8 values of sdio_i sampled on the rising serial clock edges, the first sample in bit 7.
- R6: sdio_oe is 1 only when cfg_en, cfg_master and cfg_dir_tx are all 1. sck_oe is 1 only when cfg_en and cfg_master are both 1.
- R7: done_flag is set by the eighth rising edge of a transfer. It stays set until an rx_rd or tx_wr pulse clears it, one clock after the pulse.
- R8: As slave, with the port enabled while sck_i is at its idle level, 8 rising edges of sck_i receive one byte and set done_flag. During this, sck_oe and sdio_oe stay 0.
- R9: Clearing cfg_en during a master transfer puts sck_o back at cfg_cpol within one clock and takes both output enables low. done_flag is not set, and the next transfer works normally.
- R10: A tx_wr pulse during a running master transfer neither restarts it nor changes the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = clock master, 0 = clock slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_dir_tx | input | 1 | 1 = drive the data line (master only) |
| cfg_rate | input | 2 | Master divide select: 00 /16, 01 /8, 10 /4, 11 /2 |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | DATA_W | Transmit byte |
| rx_rd | input | 1 | Receive byte read strobe |
| rx_data | output | DATA_W | Last received byte |
| done_flag | output | 1 | Transfer complete |
| sck_i | input | 1 | Serial clock from pad (slave) |
| sck_o | output | 1 | Serial clock to pad (master) |
| sck_oe | output | 1 | Serial clock pad output enable |
| sdio_i | input | 1 | Data line from pad |
| sdio_o | output | 1 | Data line to pad |
| sdio_oe | output | 1 | Data line pad output enable |

## Verification
The bench runs master transfers with both idle levels, because the first serial edge is a sampling edge with a low idle level and a launching edge with a high one. A design that shifted on that first falling edge would drop bit 7 and send the byte rotated. All four rates are measured edge to edge, so a divider off by one shows up as a wrong half-period length. One run with the high idle level writes the transmit register in the middle of a transfer; a design that reloaded on that write would send a corrupted byte. Other runs receive as slave through the synchronizer, clear the flag by a write instead of a read, and drop enable in mid-byte. After the abort, a design that kept counting would raise a spurious completion or leave the clock stuck at the wrong level.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_READY  = 2'd1,
        S_SHIFT  = 2'd2,
        S_LISTEN = 2'd3
    } hdx_state_e;
endpackage

// File: rtl/hdx_master_clk.sv
module hdx_master_clk #(
    parameter int DIV_LOG2 = 4,
    parameter int BITS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       cpol,
    input  logic [1:0] rate,
    output logic       sck_lvl,
    output logic       rise_o,
    output logic       fall_o,
    output logic       last_o
);
    localparam int HALF_MAX = 1 << (DIV_LOG2 - 1);
    localparam int CW       = (DIV_LOG2 > 1) ? DIV_LOG2 - 1 : 1;
    localparam int EDGES    = 2 * BITS;
    localparam int EW       = $clog2(EDGES);

    logic [CW-1:0] div_q;
    logic [CW-1:0] half_lim;
    logic [EW-1:0] edge_q;
    logic          tick;

    always_comb begin
        half_lim = CW'((HALF_MAX >> rate) - 1);
        tick     = run && (div_q == half_lim);
        rise_o   = tick && !sck_lvl;
        fall_o   = tick && sck_lvl;
        last_o   = tick && (edge_q == EW'(EDGES - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            edge_q  <= '0;
            sck_lvl <= 1'b0;
        end else if (!run) begin
            div_q   <= '0;
            edge_q  <= '0;
            sck_lvl <= cpol;
        end else if (tick) begin
            div_q   <= '0;
            edge_q  <= edge_q + 1'b1;
            sck_lvl <= ~sck_lvl;
        end else begin
            div_q   <= div_q + 1'b1;
        end
    end

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sck_lvl == $past(cpol));

    // R2
    toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(sck_lvl));
endmodule

// File: rtl/hdx_sck_sync.sv
module hdx_sck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sck_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        rise_o = sync_q[STAGES-1] && !prev_q;
        fall_o = !sync_q[STAGES-1] && prev_q;
    end

    // R8
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/hdx_shifter.sv
module hdx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         rise,
    input  logic         fall,
    input  logic         din,
    output logic         dout,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          smp_q;
    logic          armed_q;

    always_comb begin
        dout = sh_q[W-1];
        done = rise && !clr && (cnt_q == CW'(W - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            smp_q   <= 1'b0;
            armed_q <= 1'b0;
            rx_word <= '0;
        end else begin
            if (load) begin
                sh_q    <= load_data;
                armed_q <= 1'b0;
            end else if (fall && armed_q) begin
                sh_q    <= {sh_q[W-2:0], smp_q};
                armed_q <= 1'b0;
            end
            if (clr) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (rise) begin
                smp_q   <= din;
                armed_q <= 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    cnt_q   <= '0;
                    rx_word <= {sh_q[W-2:0], din};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R4
    hold_until_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !armed_q && !load) |=> $stable(sh_q));

    // R7
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cnt_q == '0);
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
    import hdx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_LOG2    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_dir_tx,
    input  logic [1:0]        cfg_rate,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_flag,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe
);
    hdx_state_e state_q, state_d;

    logic m_lvl, m_rise, m_fall, m_last;
    logic s_rise, s_fall;
    logic run, listen, bit_rise, bit_fall, sh_clr, sh_load, xfer_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (cfg_en) state_d = cfg_master ? S_READY : S_LISTEN;
            end
            S_READY: begin
                if (!cfg_en)          state_d = S_OFF;
                else if (!cfg_master) state_d = S_LISTEN;
                else if (tx_wr)       state_d = S_SHIFT;
            end
            S_SHIFT: begin
                if (!cfg_en)          state_d = S_OFF;
                else if (!cfg_master) state_d = S_LISTEN;
                else if (m_last)      state_d = S_READY;
            end
            S_LISTEN: begin
                if (!cfg_en)         state_d = S_OFF;
                else if (cfg_master) state_d = S_READY;
            end
            default: state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run      = (state_q == S_SHIFT);
        listen   = (state_q == S_LISTEN);
        bit_rise = run ? m_rise : (listen && s_rise);
        bit_fall = run ? m_fall : (listen && s_fall);
        sh_clr   = !(run || listen);
        sh_load  = tx_wr && ((state_q == S_READY) || listen);
        sck_o    = run ? m_lvl : cfg_cpol;
        sck_oe   = cfg_en && cfg_master;
        sdio_oe  = cfg_en && cfg_master && cfg_dir_tx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                done_flag <= 1'b0;
        else if (xfer_done)        done_flag <= 1'b1;
        else if (rx_rd || tx_wr)   done_flag <= 1'b0;
    end

    hdx_master_clk #(.DIV_LOG2(DIV_LOG2), .BITS(DATA_W)) u_mclk (
        .clk(clk), .rst_n(rst_n), .run(run), .cpol(cfg_cpol), .rate(cfg_rate),
        .sck_lvl(m_lvl), .rise_o(m_rise), .fall_o(m_fall), .last_o(m_last)
    );

    hdx_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_i), .rise_o(s_rise), .fall_o(s_fall)
    );

    hdx_shifter #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load), .load_data(tx_data),
        .rise(bit_rise), .fall(bit_fall), .din(sdio_i), .dout(sdio_o),
        .done(xfer_done), .rx_word(rx_data)
    );

    // R9
    abort_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !cfg_en) |=> state_q == S_OFF);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> done_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_rd || tx_wr) && !xfer_done) |=> !done_flag);

    // R10
    busy_write_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_wr && cfg_en && cfg_master && !m_last) |=> state_q == S_SHIFT);
endmodule

// File: tb/hdx_serial_port_tb_top.sv
module hdx_serial_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 0, cfg_master = 0, cfg_cpol = 0, cfg_dir_tx = 0;
    logic [1:0] cfg_rate = 2'b00;
    logic       tx_wr = 0, rx_rd = 0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       done_flag, sck_o, sck_oe, sdio_o, sdio_oe;
    logic       sck_i, sdio_i;

    logic       s_sck = 0, s_bit = 0, tb_mm = 1, tb_clr = 0;
    logic [7:0] mreply = 8'h00;
    logic       m_bit;

    int nvec = 0, nfail = 0, cycles = 0;
    logic [7:0] exp_q[$];

    // monitor state
    logic       prev_sck = 0, prev_sdo = 0, prev_done = 0;
    int         half_cnt = 0, tg_cnt = 0, hmin = 999, hmax = 0, rcount = 0, ridx = 0;
    logic [7:0] cap_tx = 0;
    logic       in_xfer = 0, oe_seen = 0, launch_err = 0;

    always #10 clk = ~clk;

    assign sck_i  = s_sck;
    assign m_bit  = (ridx < 8) ? mreply[7 - ridx] : 1'b0;
    assign sdio_i = tb_mm ? m_bit : s_bit;

    hdx_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_dir_tx(cfg_dir_tx), .cfg_rate(cfg_rate),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .done_flag(done_flag), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // monitor: serial slave model for master runs and scoreboard for received bytes
    always @(negedge clk) begin
        if (tb_clr || !rst_n) begin
            half_cnt = 0; tg_cnt = 0; hmin = 999; hmax = 0; rcount = 0; ridx = 0;
            cap_tx = 0; in_xfer = 0; oe_seen = 0; launch_err = 0;
            prev_sck = sck_o; prev_sdo = sdio_o;
        end else begin
            half_cnt = half_cnt + 1;
            if (sck_oe && sck_o != prev_sck) begin
                tg_cnt = tg_cnt + 1;
                if (tg_cnt > 1) begin
                    if (half_cnt < hmin) hmin = half_cnt;
                    if (half_cnt > hmax) hmax = half_cnt;
                end
                half_cnt = 0;
                if (sck_o) begin
                    rcount = rcount + 1;
                    in_xfer = 1;
                    if (sdio_oe) cap_tx = {cap_tx[6:0], sdio_o};
                end else begin
                    ridx = rcount;
                end
            end
            if (in_xfer && sdio_o != prev_sdo && !(prev_sck && !sck_o)) launch_err = 1;
            if (sdio_oe) oe_seen = 1;
            prev_sck = sck_o;
            prev_sdo = sdio_o;
        end
        if (rst_n && done_flag && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected completion", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                // R5 received byte, MSB first
                chk(rx_data == e, "R5 rx_data", rx_data, e);
            end
        end
        prev_done = done_flag;
    end

    task automatic pulse_clr();
        tb_clr = 1; @(negedge clk); tb_clr = 0;
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] reply,
                               input logic [1:0] rate, input logic cpol, input logic dir,
                               input logic busy_wr, input logic do_read);
        int t;
        cfg_en = 0; @(negedge clk);
        tb_mm = 1; cfg_master = 1; cfg_cpol = cpol; cfg_rate = rate; cfg_dir_tx = dir;
        mreply = reply; cfg_en = 1;
        repeat (3) @(negedge clk);
        // R6 output enables follow enable, master and direction
        chk(sdio_oe == dir, "R6 sdio_oe", sdio_oe, dir);
        chk(sck_oe == 1'b1, "R6 sck_oe", sck_oe, 1);
        // R3 idle level before start
        chk(sck_o == cpol, "R3 idle sck_o", sck_o, cpol);
        pulse_clr();
        exp_q.push_back(reply);
        tx_data = tx; tx_wr = 1; @(negedge clk); tx_wr = 0;
        // R7 a write clears the flag
        chk(done_flag == 1'b0, "R7 flag cleared by write", done_flag, 0);
        if (busy_wr) begin
            repeat (6) @(negedge clk);
            tx_data = ~tx; tx_wr = 1; @(negedge clk); tx_wr = 0;
        end
        t = 0;
        while (!done_flag && t < 2000) begin @(negedge clk); t++; end
        chk(done_flag == 1'b1, "R7 flag set", done_flag, 1);
        repeat (20) @(negedge clk);
        chk(sck_o == cpol, "R3 sck_o back at idle", sck_o, cpol);
        chk(tg_cnt == 16, "R3 transition count", tg_cnt, 16);
        chk(hmin == (8 >> rate) && hmax == (8 >> rate), "R2 half-period", hmax, 8 >> rate);
        chk(launch_err == 1'b0, "R4 sdio_o changed off a falling edge", launch_err, 0);
        if (dir) chk(cap_tx == tx, busy_wr ? "R10 byte after busy write" : "R4 sent byte", cap_tx, tx);
        else     chk(oe_seen == 1'b0, "R6 no drive in receive", oe_seen, 0);
        chk(done_flag == 1'b1, "R7 flag held", done_flag, 1);
        if (do_read) begin
            rx_rd = 1; @(negedge clk); rx_rd = 0;
            chk(done_flag == 1'b0, "R7 flag cleared by read", done_flag, 0);
        end
    endtask

    task automatic slave_xfer(input logic [7:0] reply, input logic cpol, input int half);
        int t;
        cfg_en = 0; @(negedge clk);
        tb_mm = 0; cfg_master = 0; cfg_cpol = cpol; cfg_dir_tx = 1;
        s_sck = cpol; s_bit = 0;
        repeat (6) @(negedge clk);
        cfg_en = 1;
        repeat (3) @(negedge clk);
        exp_q.push_back(reply);
        for (int i = 0; i < 8; i++) begin
            s_sck = 0; s_bit = reply[7 - i];
            repeat (half) @(negedge clk);
            s_sck = 1;
            repeat (half) @(negedge clk);
            // R8 no pad driven as slave
            chk(sck_oe == 1'b0 && sdio_oe == 1'b0, "R8 slave enables", {sck_oe, sdio_oe}, 0);
        end
        if (!cpol) s_sck = 0;
        t = 0;
        while (!done_flag && t < 50) begin @(negedge clk); t++; end
        chk(done_flag == 1'b1, "R8 slave completion", done_flag, 1);
        rx_rd = 1; @(negedge clk); rx_rd = 0;
        chk(done_flag == 1'b0, "R7 flag cleared by read", done_flag, 0);
    endtask

    task automatic abort_xfer();
        cfg_en = 0; @(negedge clk);
        tb_mm = 1; cfg_master = 1; cfg_cpol = 1; cfg_rate = 2'b00; cfg_dir_tx = 1;
        mreply = 8'hFF; cfg_en = 1;
        repeat (3) @(negedge clk);
        pulse_clr();
        tx_data = 8'h33; tx_wr = 1; @(negedge clk); tx_wr = 0;
        repeat (45) @(negedge clk);
        cfg_en = 0;
        @(negedge clk);
        // R9 clock back at idle, pads released
        chk(sck_o == 1'b1, "R9 sck_o idle after abort", sck_o, 1);
        chk(sck_oe == 1'b0 && sdio_oe == 1'b0, "R9 enables low", {sck_oe, sdio_oe}, 0);
        repeat (200) @(negedge clk);
        chk(done_flag == 1'b0, "R9 no completion after abort", done_flag, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sck_oe == 1'b0, "R1 sck_oe", sck_oe, 0);
        chk(sdio_oe == 1'b0, "R1 sdio_oe", sdio_oe, 0);
        chk(done_flag == 1'b0, "R1 done_flag", done_flag, 0);
        chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);

        master_xfer(8'hA5, 8'h3C, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
        master_xfer(8'h81, 8'hC3, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
        master_xfer(8'h00, 8'h96, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
        master_xfer(8'h5A, 8'h01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
        slave_xfer(8'hB7, 1'b0, 6);
        slave_xfer(8'h4E, 1'b1, 9);
        abort_xfer();
        master_xfer(8'hE1, 8'h7F, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);

        chk(exp_q.size() == 0, "R5 all bytes received", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule